// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer Group

This block holds a small group of general-purpose timer channels. Each channel has a 64-bit counter that runs up or down. A programmable prescaler divides the bus clock, and the counter steps once per prescaler period. Each channel also has a 64-bit alarm comparator, an optional reload of the counter when the alarm fires, and a level interrupt. All channels share one interrupt-enable register, one status register and one clear register.

Software reaches every register through a plain word-addressed write port and a combinational read port. The counter is never read live. Software writes a strobe, which copies the counter into a snapshot pair, and then reads both 32-bit halves of that pair at leisure. A new counter value is placed in a load pair first and takes effect only when the load strobe is written.

When an alarm fires, hardware clears the channel's arm bit. Software must set it again before the next alarm can fire.

Channel `c` occupies word addresses `8*c` to `8*c+7`. The shared registers follow at `G = 8*NUM_CH`.

Top module: `alarm_timer_group`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low. Reads of unmapped addresses return 0.
- R2: Writing a 1 to bit 0 of the channel strobe word (offset 7) copies the counter into the snapshot pair. The low half reads at offset 5 and the high half at offset 6, and both are valid from the next cycle. Nothing else changes the snapshot.
- R3: The load pair (low half at offset 1, high half at offset 2) and the alarm pair (low half at offset 3, high half at offset 4) read back as written. Writing to the load pair alone leaves the counter unchanged. Writing a 1 to bit 1 of the strobe word moves the load pair into the counter on that edge, and that edge does not also count a prescaler tick.
- R4: Configuration word (offset 0), bit 1 selects the counting direction: 1 counts up and 0 counts down. The count wraps modulo 2^64, with carry and borrow passing between the two 32-bit halves.
- R5: The divider occupies configuration bits [31:16]. The counter steps once every N bus cycles, and a value of 0 or 1 behaves as N = 2. A configuration write that changes the divider restarts the prescaler period from zero.
- R6: Configuration bit 0 enables counting. While it is 0, both the counter and the prescaler phase hold.
- R7: Configuration bit 3 arms the alarm. A tick whose new count equals the alarm pair, with the channel armed, is an alarm event. An alarm event clears bit 3 and sets the channel's raw status bit. If configuration bit 2 is set, the counter takes the load pair instead of the matching count. Otherwise counting continues from the match. A configuration write in the same cycle as an alarm event takes precedence.
- R8: At G+0, bit c is the interrupt enable for channel c. G+1 reads the raw status ANDed with the enable. Writing a 1 to bit c of G+2 clears raw bit c, but an alarm event in the same cycle wins. G+3 reads the raw status. `irq[c]` is high exactly when raw bit c, enable bit c and configuration bit 4 of channel c are all set.
- R9: While bit 3 is 0, a count that passes the alarm value sets no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (6) | Word address of the write |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (6) | Word address of the read |
| rd_data | output | DATA_W (32) | Read data, combinational from rd_addr |
| irq | output | NUM_CH (2) | Level interrupt per channel |

## Verification
The assertions assume that software sends at most one register write per cycle and that the bus holds `wr_addr` and `wr_data` steady around each edge. The clear and sticky-status checks also rely on software not writing the clear register while it expects the bit to remain set.

The stimulus drives writes and read addresses only on the falling edge, one write at a time. It sweeps the read address across the whole map on idle cycles, so that every register, including unmapped words, is compared against the behavioural model. Alarm, clear, mask and divider changes are issued in separate cycles, except where the model itself resolves the overlap.

// File: rtl/alarm_tmr_pkg.sv
package alarm_tmr_pkg;

   // register window of one channel
   localparam int CH_SPAN  = 8;
   localparam int CH_OFS_W = 3;

   typedef enum logic [CH_OFS_W-1:0] {
      OFS_CFG   = 3'd0,
      OFS_LD_LO = 3'd1,
      OFS_LD_HI = 3'd2,
      OFS_AL_LO = 3'd3,
      OFS_AL_HI = 3'd4,
      OFS_SN_LO = 3'd5,
      OFS_SN_HI = 3'd6,
      OFS_STB   = 3'd7
   } ch_reg_e;

   // configuration word bit positions
   localparam int B_RUN    = 0;
   localparam int B_UP     = 1;
   localparam int B_RELOAD = 2;
   localparam int B_ARM    = 3;
   localparam int B_LVL    = 4;

   // strobe word bit positions
   localparam int S_SNAP = 0;
   localparam int S_LOAD = 1;

   // shared words, relative to the group base
   localparam int G_IEN  = 0;
   localparam int G_IST  = 1;
   localparam int G_ICLR = 2;
   localparam int G_IRAW = 3;
   localparam int G_SPAN = 4;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 2) begin : g_bad_div_w
      $error("tmr_prescale: DIV_W must be at least 2");
   end

   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

   logic [DIV_W-1:0] pcnt_q;
   logic [DIV_W-1:0] period;

   assign period = (div < MIN_DIV) ? MIN_DIV : div;
   assign tick   = run && (pcnt_q == period - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt_q <= '0;
      else if (restart) pcnt_q <= '0;
      else if (tick)    pcnt_q <= '0;
      else if (run)     pcnt_q <= pcnt_q + DIV_W'(1);
   end

   // period is at least two cycles, so ticks never come back to back
   assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // the phase never runs past the current period
   assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q < period);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import alarm_tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DIV_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CH_OFS_W-1:0] wr_ofs,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [CH_OFS_W-1:0] rd_ofs,
   output logic [DATA_W-1:0]   rd_data,
   output logic                alarm_evt,
   output logic                lvl_ie
);

   localparam int CNT_W   = 2 * DATA_W;
   localparam int DIV_LSB = DATA_W - DIV_W;

   if (DIV_LSB <= B_LVL) begin : g_bad_layout
      $error("tmr_channel: divider field overlaps the control bits");
   end

   logic              cfg_run, cfg_up, cfg_reload, cfg_arm, cfg_lvl;
   logic [DIV_W-1:0]  cfg_div;
   logic [CNT_W-1:0]  count_q, load_q, alarm_q, snap_q;
   logic [CNT_W-1:0]  count_step;
   logic              cfg_wr, stb_wr, load_stb, snap_stb, restart, tick;
   logic [DIV_W-1:0]  new_div;

   assign cfg_wr   = wr_en && (wr_ofs == OFS_CFG);
   assign stb_wr   = wr_en && (wr_ofs == OFS_STB);
   assign load_stb = stb_wr && wr_data[S_LOAD];
   assign snap_stb = stb_wr && wr_data[S_SNAP];
   assign new_div  = wr_data[DATA_W-1:DIV_LSB];
   assign restart  = cfg_wr && (new_div != cfg_div);

   tmr_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cfg_run),
      .restart (restart),
      .div     (cfg_div),
      .tick    (tick)
   );

   assign count_step = cfg_up ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
   assign alarm_evt  = tick && cfg_arm && !load_stb && (count_step == alarm_q);
   assign lvl_ie     = cfg_lvl;

   // counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        count_q <= '0;
      else if (load_stb)                 count_q <= load_q;
      else if (alarm_evt && cfg_reload)  count_q <= load_q;
      else if (tick)                     count_q <= count_step;
   end

   // configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_run    <= 1'b0;
         cfg_up     <= 1'b0;
         cfg_reload <= 1'b0;
         cfg_arm    <= 1'b0;
         cfg_lvl    <= 1'b0;
         cfg_div    <= '0;
      end else if (cfg_wr) begin
         cfg_run    <= wr_data[B_RUN];
         cfg_up     <= wr_data[B_UP];
         cfg_reload <= wr_data[B_RELOAD];
         cfg_arm    <= wr_data[B_ARM];
         cfg_lvl    <= wr_data[B_LVL];
         cfg_div    <= new_div;
      end else if (alarm_evt) begin
         cfg_arm    <= 1'b0;
      end
   end

   // load, alarm and snapshot words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q  <= '0;
         alarm_q <= '0;
         snap_q  <= '0;
      end else begin
         if (wr_en && wr_ofs == OFS_LD_LO) load_q[DATA_W-1:0]      <= wr_data;
         if (wr_en && wr_ofs == OFS_LD_HI) load_q[CNT_W-1:DATA_W]  <= wr_data;
         if (wr_en && wr_ofs == OFS_AL_LO) alarm_q[DATA_W-1:0]     <= wr_data;
         if (wr_en && wr_ofs == OFS_AL_HI) alarm_q[CNT_W-1:DATA_W] <= wr_data;
         if (snap_stb)                     snap_q                  <= count_q;
      end
   end

   // read mux
   always_comb begin
      rd_data = '0;
      case (ch_reg_e'(rd_ofs))
         OFS_CFG: begin
            rd_data[B_RUN]    = cfg_run;
            rd_data[B_UP]     = cfg_up;
            rd_data[B_RELOAD] = cfg_reload;
            rd_data[B_ARM]    = cfg_arm;
            rd_data[B_LVL]    = cfg_lvl;
            rd_data[DATA_W-1:DIV_LSB] = cfg_div;
         end
         OFS_LD_LO: rd_data = load_q[DATA_W-1:0];
         OFS_LD_HI: rd_data = load_q[CNT_W-1:DATA_W];
         OFS_AL_LO: rd_data = alarm_q[DATA_W-1:0];
         OFS_AL_HI: rd_data = alarm_q[CNT_W-1:DATA_W];
         OFS_SN_LO: rd_data = snap_q[DATA_W-1:0];
         OFS_SN_HI: rd_data = snap_q[CNT_W-1:DATA_W];
         default:   rd_data = '0;
      endcase
   end

   assert_snap_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      snap_stb |=> snap_q == $past(count_q));

   assert_load_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> count_q == $past(load_q));

   assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_run && !load_stb) |=> count_q == $past(count_q));

   assert_alarm_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_evt && !cfg_wr) |=> !cfg_arm);

   assert_alarm_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_evt && cfg_reload) |=> count_q == $past(load_q));

endmodule

// File: rtl/alarm_timer_group.sv
module alarm_timer_group
   import alarm_tmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32,
   parameter int DIV_W  = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] irq
);

   localparam int GRP_BASE = NUM_CH * CH_SPAN;
   localparam int IDX_W    = ADDR_W - CH_OFS_W;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_num_ch
      $error("alarm_timer_group: NUM_CH out of range");
   end
   if (GRP_BASE + G_SPAN > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("alarm_timer_group: ADDR_W too small for the register map");
   end

   logic [NUM_CH-1:0] evt, lvl, ien_q, raw_q, clr_mask;
   logic [NUM_CH-1:0] ch_wr;
   logic [DATA_W-1:0] ch_rd [NUM_CH];
   logic              wr_in_ch, ien_wr, iclr_wr;

   assign wr_in_ch = int'(wr_addr) < GRP_BASE;
   assign ien_wr   = wr_en && (wr_addr == ADDR_W'(GRP_BASE + G_IEN));
   assign iclr_wr  = wr_en && (wr_addr == ADDR_W'(GRP_BASE + G_ICLR));
   assign clr_mask = iclr_wr ? wr_data[NUM_CH-1:0] : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_wr[i] = wr_en && wr_in_ch
                        && (wr_addr[ADDR_W-1:CH_OFS_W] == IDX_W'(i));

      tmr_channel #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (ch_wr[i]),
         .wr_ofs    (wr_addr[CH_OFS_W-1:0]),
         .wr_data   (wr_data),
         .rd_ofs    (rd_addr[CH_OFS_W-1:0]),
         .rd_data   (ch_rd[i]),
         .alarm_evt (evt[i]),
         .lvl_ie    (lvl[i])
      );

      // clearing only removes a bit when no alarm lands on the same edge
      assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (iclr_wr && wr_data[i] && !evt[i]) |=> !raw_q[i]);

      // status stays pending until it is cleared, whatever the mask does
      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (raw_q[i] && !(iclr_wr && wr_data[i])) |=> raw_q[i]);

      // an alarm always leaves the pending bit set
      assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> raw_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
         raw_q <= '0;
      end else begin
         if (ien_wr) ien_q <= wr_data[NUM_CH-1:0];
         raw_q <= evt | (raw_q & ~clr_mask);
      end
   end

   assign irq = raw_q & ien_q & lvl;

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < GRP_BASE) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr[ADDR_W-1:CH_OFS_W] == IDX_W'(i)) rd_data = ch_rd[i];
         end
      end else if (rd_addr == ADDR_W'(GRP_BASE + G_IEN)) begin
         rd_data[NUM_CH-1:0] = ien_q;
      end else if (rd_addr == ADDR_W'(GRP_BASE + G_IST)) begin
         rd_data[NUM_CH-1:0] = raw_q & ien_q;
      end else if (rd_addr == ADDR_W'(GRP_BASE + G_IRAW)) begin
         rd_data[NUM_CH-1:0] = raw_q;
      end
   end

endmodule

// File: tb/test_alarm_timer_group.sv
module test_alarm_timer_group;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  irq;

   int n_cmp = 0;
   int n_bad = 0;
   int sweep = 0;

   always #2 clk = ~clk;   // 250 MHz

   alarm_timer_group i_alarm_timer_group (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .irq     (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [63:0] m_cnt [2];
   logic [63:0] m_ld  [2];
   logic [63:0] m_al  [2];
   logic [63:0] m_sn  [2];
   logic [15:0] m_div [2];
   int          m_pc  [2];
   bit          m_run [2];
   bit          m_up  [2];
   bit          m_rl  [2];
   bit          m_arm [2];
   bit          m_lvl [2];
   bit   [1:0]  m_ien;
   bit   [1:0]  m_raw;

   function automatic void m_reset();
      for (int c = 0; c < 2; c++) begin
         m_cnt[c] = '0; m_ld[c] = '0; m_al[c] = '0; m_sn[c] = '0;
         m_div[c] = '0; m_pc[c] = 0;
         m_run[c] = 0; m_up[c] = 0; m_rl[c] = 0; m_arm[c] = 0; m_lvl[c] = 0;
      end
      m_ien = '0;
      m_raw = '0;
   endfunction

   function automatic void m_step();
      bit [1:0] evts;
      bit [1:0] clr;
      evts = '0;
      for (int c = 0; c < 2; c++) begin
         int per;
         bit tk, w, lstb, sstb, ev;
         int o;
         logic [63:0] nx;
         per  = (m_div[c] < 2) ? 2 : int'(m_div[c]);
         tk   = m_run[c] && (m_pc[c] == per - 1);
         w    = wr_en && (int'(wr_addr) < 16) && (int'(wr_addr) / 8 == c);
         o    = int'(wr_addr) % 8;
         lstb = w && o == 7 && wr_data[1];
         sstb = w && o == 7 && wr_data[0];
         nx   = m_up[c] ? m_cnt[c] + 64'd1 : m_cnt[c] - 64'd1;
         ev   = tk && m_arm[c] && !lstb && (nx == m_al[c]);
         if (sstb) m_sn[c] = m_cnt[c];
         if (w && o == 0 && wr_data[31:16] != m_div[c]) m_pc[c] = 0;
         else if (tk) m_pc[c] = 0;
         else if (m_run[c]) m_pc[c] = m_pc[c] + 1;
         if (lstb) m_cnt[c] = m_ld[c];
         else if (ev && m_rl[c]) m_cnt[c] = m_ld[c];
         else if (tk) m_cnt[c] = nx;
         if (w && o == 0) begin
            m_run[c] = wr_data[0]; m_up[c] = wr_data[1]; m_rl[c] = wr_data[2];
            m_arm[c] = wr_data[3]; m_lvl[c] = wr_data[4]; m_div[c] = wr_data[31:16];
         end else if (ev) m_arm[c] = 0;
         if (w && o == 1) m_ld[c][31:0]  = wr_data;
         if (w && o == 2) m_ld[c][63:32] = wr_data;
         if (w && o == 3) m_al[c][31:0]  = wr_data;
         if (w && o == 4) m_al[c][63:32] = wr_data;
         evts[c] = ev;
      end
      clr = (wr_en && wr_addr == 6'd18) ? wr_data[1:0] : 2'b00;
      m_raw = evts | (m_raw & ~clr);
      if (wr_en && wr_addr == 6'd16) m_ien = wr_data[1:0];
   endfunction

   function automatic logic [31:0] m_read(int a);
      int c, o;
      if (a < 16) begin
         c = a / 8;
         o = a % 8;
         case (o)
            0: return {m_div[c], 11'd0, m_lvl[c], m_arm[c], m_rl[c], m_up[c], m_run[c]};
            1: return m_ld[c][31:0];
            2: return m_ld[c][63:32];
            3: return m_al[c][31:0];
            4: return m_al[c][63:32];
            5: return m_sn[c][31:0];
            6: return m_sn[c][63:32];
            default: return 32'd0;
         endcase
      end
      if (a == 16) return {30'd0, m_ien};
      if (a == 17) return {30'd0, m_raw & m_ien};
      if (a == 19) return {30'd0, m_raw};
      return 32'd0;
   endfunction

   function automatic logic [1:0] m_irq();
      return m_raw & m_ien & {m_lvl[1], m_lvl[0]};
   endfunction

   function automatic string tag_of(int a);
      if (a >= 16) return "R8";
      case (a % 8)
         0:       return "R7";
         5, 6:    return "R2";
         default: return "R3";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else        m_step();
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // compare every cycle after the edge has settled
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         chk(tag_of(int'(rd_addr)), rd_data, m_read(int'(rd_addr)));
         chk("R8 irq", {30'd0, irq}, {30'd0, m_irq()});
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 6'(a);
      wr_data = d;
      rd_addr = 6'(sweep % 21);
      sweep++;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_en   = 1'b0;
         rd_addr = 6'(sweep % 21);
         sweep++;
      end
   endtask

   task automatic peek(int a);
      @(negedge clk);
      wr_en   = 1'b0;
      rd_addr = 6'(a);
      @(posedge clk);
      #1;
   endtask

   task automatic snap_chk(int ch, string tag);
      wr(ch * 8 + 7, 32'h1);
      peek(ch * 8 + 5);
      chk(tag, rd_data, m_read(ch * 8 + 5));
      peek(ch * 8 + 6);
      chk(tag, rd_data, m_read(ch * 8 + 6));
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, hand values
      peek(0);  chk("R1 cfg0", rd_data, 32'd0);
      peek(13); chk("R1 snap1 lo", rd_data, 32'd0);
      peek(19); chk("R1 raw", rd_data, 32'd0);
      peek(23); chk("R1 unmapped", rd_data, 32'd0);
      chk("R1 irq", {30'd0, irq}, 32'd0);

      // R3 / R4 / R5: ch0 count up from 100, divide by 3
      wr(1, 32'd100);
      wr(2, 32'd0);
      idle(4);
      snap_chk(0, "R3 load regs alone leave counter");
      wr(7, 32'h2);
      wr(0, (32'd3 << 16) | 32'h3);
      idle(40);
      snap_chk(0, "R5 divide by 3 up count");

      // R4: ch1 count down through zero, divider 0 behaves as 2
      wr(9, 32'd5);
      wr(10, 32'd0);
      wr(15, 32'h2);
      wr(8, 32'h1);
      idle(30);
      snap_chk(1, "R4 down count wraps");

      // R6: pause ch1
      wr(8, 32'h0);
      idle(5);
      snap_chk(1, "R6 paused");
      idle(20);
      snap_chk(1, "R6 still paused");

      // R4: carry across the half boundary
      wr(9, 32'hFFFF_FFFE);
      wr(10, 32'h0000_0001);
      wr(15, 32'h2);
      wr(8, 32'h3);
      idle(12);
      snap_chk(1, "R4 carry into high half");

      // R7: alarm without reload on ch0
      wr(16, 32'h3);
      wr(1, 32'd0);
      wr(2, 32'd0);
      wr(7, 32'h2);
      wr(3, 32'd20);
      wr(4, 32'd0);
      wr(0, (32'd2 << 16) | 32'h1B);
      idle(80);
      peek(19); chk("R7 raw set by alarm", rd_data, 32'h1);
      peek(0);  chk("R7 arm self-cleared", rd_data, 32'h0002_0013);
      chk("R8 irq high", {30'd0, irq}, 32'h1);
      snap_chk(0, "R7 keeps counting");

      // R8: mask hides status and irq but raw stays
      wr(16, 32'h0);
      peek(17); chk("R8 masked status", rd_data, 32'h0);
      peek(19); chk("R8 raw sticky", rd_data, 32'h1);
      chk("R8 irq masked", {30'd0, irq}, 32'h0);
      wr(16, 32'h3);
      wr(18, 32'h1);
      peek(19); chk("R8 cleared", rd_data, 32'h0);

      // R7: reload mode, re-armed several times
      wr(1, 32'd3);
      wr(7, 32'h2);
      wr(3, 32'd10);
      for (int k = 0; k < 4; k++) begin
         wr(0, (32'd2 << 16) | 32'h1F);
         idle(25);
         snap_chk(0, "R7 reload");
         wr(18, 32'h1);
      end

      // R9: no arm, counter passes the alarm value
      wr(0, 32'h0);
      wr(18, 32'h3);
      wr(1, 32'd0);
      wr(7, 32'h2);
      wr(3, 32'd5);
      wr(0, (32'd2 << 16) | 32'h13);
      idle(40);
      peek(19); chk("R9 no alarm while disarmed", rd_data, 32'h0);

      // R5: divider change restarts the prescaler
      wr(0, (32'd7 << 16) | 32'h3);
      idle(3);
      wr(0, (32'd5 << 16) | 32'h3);
      idle(17);
      snap_chk(0, "R5 restart on new divider");

      // R8: clear colliding with an alarm, ch1 in reload mode
      wr(9, 32'd0);
      wr(10, 32'd0);
      wr(15, 32'h2);
      wr(11, 32'd2);
      wr(12, 32'd0);
      wr(8, 32'h1F);
      for (int k = 0; k < 8; k++) begin
         wr(18, 32'h2);
         wr(8, 32'h1F);
      end
      idle(10);
      peek(17); chk("R8 status after collisions", rd_data, m_read(17));

      idle(30);
      finish_run();
   end

endmodule